// File: doc/BRIEF.md
# Radix-4 Flag-Digit Sequential Divider

This block divides an unsigned 8-bit dividend by an unsigned 8-bit divisor and returns quotient and remainder, with one quotient digit of two bits (radix 4) settled per pass. When a division is accepted, the divisor is split into two parts. The head is its most significant nonzero radix-4 digit. The flag is the group of lower digits beneath the head. Each quotient digit is estimated by comparing the leading part of the working remainder against the head alone. The trial subtraction then removes two terms: the head product and the cross-product of the digit with the flag. When that trial result goes negative, the digit is decremented and the trial is repeated. A divisor of one digit has an empty flag, so the block then works as plain digit-by-digit division.

The controller has four states. `S_IDLE` waits for `start_i`. `S_EST` forms the head-only digit estimate. `S_TRIAL` applies the trial subtraction, and then either corrects the digit or commits it. `S_DONE` presents the result for one cycle. Its transitions are named as follows:
- accept: `S_IDLE` to `S_EST`, on start with a nonzero divisor.
- zero-reject: `S_IDLE` to `S_DONE`, on start with a zero divisor.
- estimate: `S_EST` to `S_TRIAL`.
- correct: `S_TRIAL` to `S_TRIAL`, when the trial is negative.
- next-digit: `S_TRIAL` to `S_EST`, on commit while lower digits remain.
- finish: `S_TRIAL` to `S_DONE`, on commit of digit 0.
- release: `S_DONE` to `S_IDLE`.

Top module: `flag_digit_divider`

## Requirements
- R1: For a nonzero divisor, the result reported with done equals the floor of dividend divided by divisor, and the remainder equals dividend minus quotient times divisor.
- R2: For a nonzero divisor, the reported remainder is always below the divisor.
- R3: For a zero divisor, the block finishes one cycle after start and reports div_zero_o = 1, quotient 0xFF and remainder equal to the dividend.
- R4: div_zero_o is 0 on every completion that has a nonzero divisor, including the first completion after a zero-divisor operation.
- R5: The head is the highest nonzero bit pair of the divisor. The pairs are [7:6], [5:4], [3:2] and [1:0]. The flag is the value of the pairs below the head. The result is correct for every head position.
- R6: Each digit estimate is the largest value from 0 to 3 whose product with the head does not exceed the leading part of the working remainder. A negative trial decrements the digit by one per cycle, and it never decrements a zero digit.
- R7: done_o is high for exactly one cycle per operation. quotient_o, remainder_o and div_zero_o hold their values until the next completion.
- R8: start_i is ignored in every state except S_IDLE, including the S_DONE cycle. Such a start neither alters the running operation nor produces a further done.
- R9: After reset, done_o, div_zero_o, quotient_o and remainder_o are all 0.
- R10: Divisors 1 to 3 have an empty flag, and they give correct results for every dividend tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a division; sampled only in S_IDLE |
| dividend_i | input | 8 | Unsigned dividend, captured at accept |
| divisor_i | input | 8 | Unsigned divisor, captured at accept |
| quotient_o | output | 8 | Quotient of the last completed operation |
| remainder_o | output | 8 | Remainder of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed operation had a zero divisor |

## Verification
Two events can land on the same clock: a completion, and a fresh start request that arrives while the block is busy or sitting in the S_DONE cycle. The bench provokes this by raising start with different operands partway through a division, and again during the exact cycle in which done is high. It then requires three things: the first operation's quotient and remainder, no second done pulse, and outputs that stay unchanged. The arithmetic is judged by a sweep over all 255 nonzero divisors against a strided dividend set plus the values around each divisor, compared with the integer / and % results.

// File: rtl/flag_div_pkg.sv
package flag_div_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_EST,
        S_TRIAL,
        S_DONE
    } fd_state_e;
endpackage

// File: rtl/flag_div_split.sv
// Splits a divisor into its leading nonzero digit (head) and the value below it (flag).
module flag_div_split #(
    parameter int WIDTH = 8,
    parameter int DB    = 2,
    localparam int NDIG = WIDTH / DB,
    localparam int IDXW = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic [WIDTH-1:0] divisor_i,
    output logic [DB-1:0]    head_o,
    output logic [IDXW-1:0]  hpos_o,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] mask;

    always_comb begin
        head_o = '0;
        hpos_o = '0;
        for (int i = 0; i < NDIG; i++) begin
            if (divisor_i[i*DB +: DB] != '0) begin
                head_o = divisor_i[i*DB +: DB];
                hpos_o = IDXW'(i);
            end
        end
        mask   = (WIDTH'(1) << (DB * int'(hpos_o))) - WIDTH'(1);
        flag_o = divisor_i & mask;
    end
endmodule

// File: rtl/flag_div_est.sv
// Head-only digit estimate: largest digit value whose product with the head fits.
module flag_div_est #(
    parameter int WIDTH = 8,
    parameter int DB    = 2
) (
    input  logic [WIDTH-1:0] part_i,
    input  logic [DB-1:0]    head_i,
    output logic [DB-1:0]    q_o
);
    always_comb begin
        q_o = '0;
        for (int v = 1; v < (1 << DB); v++) begin
            if ((v * int'(head_i)) <= int'(part_i)) begin
                q_o = DB'(v);
            end
        end
    end
endmodule

// File: rtl/flag_div_trial.sv
// Trial subtraction: head product and flag cross-product, both aligned to the digit column.
module flag_div_trial #(
    parameter int WIDTH = 8,
    parameter int DB    = 2,
    localparam int NDIG = WIDTH / DB,
    localparam int IDXW = (NDIG > 1) ? $clog2(NDIG) : 1,
    localparam int TW   = 2 * WIDTH + DB + 2
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [DB-1:0]    q_i,
    input  logic [DB-1:0]    head_i,
    input  logic [WIDTH-1:0] flag_i,
    input  logic [IDXW-1:0]  kpos_i,
    input  logic [IDXW-1:0]  hpos_i,
    output logic [WIDTH-1:0] next_rem_o,
    output logic             neg_o
);
    logic [TW-1:0] head_term;
    logic [TW-1:0] flag_term;
    logic [TW-1:0] diff;

    always_comb begin
        head_term  = (TW'(q_i) * TW'(head_i)) << (DB * (int'(kpos_i) + int'(hpos_i)));
        flag_term  = (TW'(q_i) * TW'(flag_i)) << (DB * int'(kpos_i));
        diff       = TW'(rem_i) - head_term - flag_term;
        neg_o      = diff[TW-1];
        next_rem_o = diff[WIDTH-1:0];
    end
endmodule

// File: rtl/flag_digit_divider.sv
module flag_digit_divider
    import flag_div_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DB    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             done_o,
    output logic             div_zero_o
);
    localparam int NDIG = WIDTH / DB;
    localparam int IDXW = (NDIG > 1) ? $clog2(NDIG) : 1;

    fd_state_e state_q, state_d;

    logic [WIDTH-1:0] dvd_q, dvs_q, flag_q, rem_q, quo_q;
    logic [DB-1:0]    head_q, qdig_q;
    logic [IDXW-1:0]  hpos_q, kpos_q;

    logic [DB-1:0]    split_head;
    logic [IDXW-1:0]  split_hpos;
    logic [WIDTH-1:0] split_flag;
    logic [WIDTH-1:0] part;
    logic [DB-1:0]    est_q;
    logic [WIDTH-1:0] trial_rem;
    logic             trial_neg;
    logic [WIDTH-1:0] quo_fin;
    logic [WIDTH-1:0] quo_res, rem_res;
    logic             zero_res;

    flag_div_split #(.WIDTH(WIDTH), .DB(DB)) u_split (
        .divisor_i (divisor_i),
        .head_o    (split_head),
        .hpos_o    (split_hpos),
        .flag_o    (split_flag)
    );

    assign part = rem_q >> (DB * (int'(kpos_q) + int'(hpos_q)));

    flag_div_est #(.WIDTH(WIDTH), .DB(DB)) u_est (
        .part_i (part),
        .head_i (head_q),
        .q_o    (est_q)
    );

    flag_div_trial #(.WIDTH(WIDTH), .DB(DB)) u_trial (
        .rem_i      (rem_q),
        .q_i        (qdig_q),
        .head_i     (head_q),
        .flag_i     (flag_q),
        .kpos_i     (kpos_q),
        .hpos_i     (hpos_q),
        .next_rem_o (trial_rem),
        .neg_o      (trial_neg)
    );

    assign quo_fin = quo_q | (WIDTH'(qdig_q) << (DB * int'(kpos_q)));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = (divisor_i == '0) ? S_DONE : S_EST;
            S_EST:   state_d = S_TRIAL;
            S_TRIAL: begin
                if (trial_neg)            state_d = S_TRIAL;
                else if (kpos_q == '0)    state_d = S_DONE;
                else                      state_d = S_EST;
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Working datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            dvs_q  <= '0;
            flag_q <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            head_q <= '0;
            qdig_q <= '0;
            hpos_q <= '0;
            kpos_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    dvd_q  <= dividend_i;
                    dvs_q  <= divisor_i;
                    head_q <= split_head;
                    hpos_q <= split_hpos;
                    flag_q <= split_flag;
                    rem_q  <= dividend_i;
                    quo_q  <= '0;
                    kpos_q <= IDXW'(NDIG - 1) - split_hpos;
                end
                S_EST:   qdig_q <= est_q;
                S_TRIAL: begin
                    if (trial_neg) begin
                        qdig_q <= qdig_q - DB'(1);
                    end else begin
                        rem_q <= trial_rem;
                        quo_q <= quo_fin;
                        if (kpos_q != '0) kpos_q <= kpos_q - IDXW'(1);
                    end
                end
                S_DONE:  ;
                default: ;
            endcase
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_res  <= '0;
            rem_res  <= '0;
            zero_res <= 1'b0;
        end else if (state_q == S_IDLE && start_i && divisor_i == '0) begin
            quo_res  <= '1;
            rem_res  <= dividend_i;
            zero_res <= 1'b1;
        end else if (state_q == S_TRIAL && !trial_neg && kpos_q == '0) begin
            quo_res  <= quo_fin;
            rem_res  <= trial_rem;
            zero_res <= 1'b0;
        end
    end

    assign quotient_o  = quo_res;
    assign remainder_o = rem_res;
    assign div_zero_o  = zero_res;
    assign done_o      = (state_q == S_DONE);

    p_quot_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |->
        ((2*WIDTH)'(quotient_o) * (2*WIDTH)'(dvs_q) + (2*WIDTH)'(remainder_o)) == (2*WIDTH)'(dvd_q));

    p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |-> (remainder_o < dvs_q));

    p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (div_zero_o == (dvs_q == '0)));

    p_head_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && dvs_q != '0) |-> (head_q != '0));

    p_no_digit_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRIAL && trial_neg) |-> (qdig_q != '0));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start_i) |=> ($stable(dvd_q) && $stable(dvs_q)));
endmodule

// File: tb/flag_digit_divider_bench.sv
`timescale 1ns/1ps
module flag_digit_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] dvd = '0;
    logic [7:0] dvs = '0;
    logic [7:0] quotient, remainder;
    logic       done, dz;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    flag_digit_divider u_flag_digit_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .dividend_i  (dvd),
        .divisor_i   (dvs),
        .quotient_o  (quotient),
        .remainder_o (remainder),
        .done_o      (done),
        .div_zero_o  (dz)
    );

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=still running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic run_op(input logic [7:0] a, input logic [7:0] b, output bit seen);
        @(negedge clk);
        start = 1'b1; dvd = a; dvs = b;
        seen = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic check_op(input string tag, input logic [7:0] a, input logic [7:0] b);
        bit seen;
        logic [7:0] eq, er;
        logic ez;
        if (b == 0) begin eq = 8'hFF; er = a; ez = 1'b1; end
        else begin eq = a / b; er = a % b; ez = 1'b0; end
        run_op(a, b, seen);
        checks++;
        if (!seen || quotient !== eq || remainder !== er || dz !== ez) begin
            failures++;
            $display("FAIL %s a=%0d b=%0d got done=%0d q=%0d r=%0d z=%0d exp q=%0d r=%0d z=%0d",
                     tag, a, b, seen, quotient, remainder, dz, eq, er, ez);
        end
    endtask

    task automatic expect_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    initial begin
        bit seen;
        bit extra;
        repeat (3) @(negedge clk);
        // R9: reset values
        checks++;
        if (done !== 1'b0 || dz !== 1'b0 || quotient !== 8'd0 || remainder !== 8'd0) begin
            failures++;
            $display("FAIL R9 reset got done=%0d z=%0d q=%0d r=%0d exp 0 0 0 0", done, dz, quotient, remainder);
        end
        rst_n = 1'b1;

        // R3: zero divisor
        check_op("R3", 8'd0, 8'd0);
        check_op("R3", 8'h5A, 8'd0);
        check_op("R3", 8'hFF, 8'd0);
        // R4: flag clears on the next good operation
        check_op("R4", 8'd100, 8'd9);

        // R6: head 1 with large flag forces digit corrections
        check_op("R6", 8'd255, 8'h1F);
        check_op("R6", 8'd200, 8'h17);
        check_op("R6", 8'd127, 8'h07);

        // R7: done lasts one cycle and results hold
        run_op(8'd77, 8'd5, seen);
        expect_bit("R7 done seen", seen, 1'b1);
        @(negedge clk);
        expect_bit("R7 done low next cycle", done, 1'b0);
        checks++;
        if (quotient !== 8'd15 || remainder !== 8'd2) begin
            failures++;
            $display("FAIL R7 hold got q=%0d r=%0d exp q=15 r=2", quotient, remainder);
        end

        // R8: start while busy and in the done cycle is ignored
        @(negedge clk);
        start = 1'b1; dvd = 8'd200; dvs = 8'd7;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        start = 1'b1; dvd = 8'd9; dvs = 8'd3;
        @(negedge clk); start = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        checks++;
        if (!seen || quotient !== 8'd28 || remainder !== 8'd4) begin
            failures++;
            $display("FAIL R8 busy start got done=%0d q=%0d r=%0d exp q=28 r=4", seen, quotient, remainder);
        end
        start = 1'b1; dvd = 8'd9; dvs = 8'd3;
        @(negedge clk); start = 1'b0;
        extra = 1'b0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
        end
        expect_bit("R8 no extra done", extra, 1'b0);
        checks++;
        if (quotient !== 8'd28 || remainder !== 8'd4) begin
            failures++;
            $display("FAIL R8 done-cycle start got q=%0d r=%0d exp q=28 r=4", quotient, remainder);
        end

        // R1, R2, R5, R10: sweep over all nonzero divisors
        for (int b = 1; b < 256; b++) begin
            string tag;
            if (b < 4)        tag = "R10 R1 R2";
            else if (b < 16)  tag = "R5 head[3:2] R1 R2";
            else if (b < 64)  tag = "R5 head[5:4] R1 R2";
            else              tag = "R5 head[7:6] R1 R2";
            for (int i = 0; i < 16; i++) begin
                check_op(tag, 8'((i * 17) & 255), 8'(b));
            end
            check_op(tag, 8'(b - 1), 8'(b));
            check_op(tag, 8'(b), 8'(b));
            check_op(tag, 8'((b * 3) & 255), 8'(b));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule